// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Event Input

This block is one timer channel. Software loads an initial value, then starts the channel. The channel counts down by one on every count tick. When it is already at zero and another tick arrives, it reloads the initial value and raises a one-cycle underflow pulse.

In timer mode, the ticks come from a prescaler. The prescaler counts single-cycle enable strobes from either a slow or a fast source clock, and divides them by 1, 4, 32 or 256. The fast source only produces strobes once its "on" flag is raised, and that flag is low out of reset.

In event mode, the prescaler and the source settings play no part. The ticks come instead from an external pin. The pin is synchronised to the system clock and may be passed through a noise filter. A polarity bit then picks whether rising or falling edges are counted.

All logic runs on one system clock with an asynchronous active-low reset.

Top module: `cdt_timer`

## Requirements
- R1: After reset, `count` is 0 and `underflow` is 0.
- R2: A pulse on `reload_wr` stores `reload_val` as the reload value. While `run` is 0, the same pulse also loads `count` on the next cycle. While `run` is 1, `count` is left unchanged by the write.
- R3: `ratio_code` sets how many source strobes make one tick: code 0 gives 1, code 1 gives 4, code 2 gives 32 and code 3 gives 256.
- R4: `src_sel`=0 counts `lo_stb`, and `src_sel`=1 counts `hi_stb`. The strobe of the source that is not selected is ignored. `hi_stb` is also ignored while `hi_on` is 0.
- R5: While `run` is 0, both `count` and the prescaler hold their values. On a 0-to-1 change of `run`, the prescaler restarts from zero, so the first tick needs a full divided period of strobes.
- R6: Each tick while `run` is 1 lowers `count` by one. A tick at `count`=0 loads the reload value and makes `underflow` 1 for that cycle.
- R7: With `event_mode`=1, source strobes, `src_sel` and `ratio_code` have no effect on `count`. Edges on `evt_pin` drive the count instead.
- R8: In event mode, `edge_pol`=1 counts rising edges of `evt_pin` and `edge_pol`=0 counts falling edges. The other edge is ignored.
- R9: With `filt_en`=1, a new pin level is accepted only when two consecutive `filt_stb` samples agree on it, so a pulse shorter than the strobe spacing is not counted. With `filt_en`=0, every synchronised level change is passed on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Prescaler source: 0 slow, 1 fast |
| ratio_code | input | 2 | Division code: 0 /1, 1 /4, 2 /32, 3 /256 |
| run | input | 1 | Run enable for the prescaler and counter |
| event_mode | input | 1 | 1 counts pin edges instead of prescaler ticks |
| edge_pol | input | 1 | Counted edge: 1 rising, 0 falling |
| filt_en | input | 1 | Enables the pin noise filter |
| reload_val | input | CNT_W | Initial/reload value |
| reload_wr | input | 1 | Write strobe for reload_val |
| lo_stb | input | 1 | Slow source clock enable strobe |
| hi_stb | input | 1 | Fast source clock enable strobe |
| hi_on | input | 1 | Fast source running flag, low after reset |
| filt_stb | input | 1 | Noise filter sampling strobe |
| evt_pin | input | 1 | External event input |
| count | output | CNT_W | Current counter value |
| underflow | output | 1 | One-cycle pulse on reload after zero |

## Verification
The bench targets the exact strobe count at which each division ratio yields its first tick. A prescaler whose compare is off by one, or which mixes up two codes, ticks one strobe early or late.

A separate check stops the channel in the middle of a period and then restarts it. A prescaler that is not cleared on restart decrements after too few strobes.

The wrap from zero checks both the reloaded value and the underflow pulse. It also confirms that a reload written while running waits until the next wrap, and does not disturb the live count.

Event tests toggle the pin in both directions under each polarity, then send a short glitch with the filter on and off. A missing filter would count the glitch. A swapped polarity would count on the wrong edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned PSC_W = 8;

  // Last prescaler state before a tick, per two-bit ratio code
  function automatic logic [PSC_W-1:0] div_last(input logic [1:0] code);
    case (code)
      2'd0:    return PSC_W'(0);
      2'd1:    return PSC_W'(3);
      2'd2:    return PSC_W'(31);
      default: return PSC_W'(255);
    endcase
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       en,
  input  logic       src_sel,
  input  logic       hi_on,
  input  logic       lo_stb,
  input  logic       hi_stb,
  input  logic [1:0] ratio,
  output logic       tick
);
  logic             run_q;
  logic [PSC_W-1:0] pcnt_q, pcnt_d, base;
  logic             src_stb;

  always_comb begin
    src_stb = src_sel ? (hi_stb & hi_on) : lo_stb;
    base    = (run && !run_q) ? '0 : pcnt_q;
    pcnt_d  = pcnt_q;
    tick    = 1'b0;
    if (en) begin
      pcnt_d = base;
      if (src_stb) begin
        if (base >= div_last(ratio)) begin
          pcnt_d = '0;
          tick   = 1'b1;
        end else begin
          pcnt_d = base + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      run_q  <= run;
      pcnt_q <= pcnt_d;
    end
  end

  AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pcnt_q)); // R5
  AST_PSC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt_q == '0)); // R3
endmodule

// File: rtl/cdt_evt_filter.sv
module cdt_evt_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic filt_en,
  input  logic filt_stb,
  input  logic pol,
  output logic edge_tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic synced;
  logic samp_q, samp_d;
  logic lvl_q, lvl_d;
  logic prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];

  always_comb begin
    samp_d = samp_q;
    lvl_d  = lvl_q;
    if (filt_en) begin
      if (filt_stb) begin
        samp_d = synced;
        if (synced == samp_q) lvl_d = synced;
      end
    end else begin
      samp_d = synced;
      lvl_d  = synced;
    end
    edge_tick = pol ? (lvl_q & ~prev_q) : (~lvl_q & prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      lvl_q  <= lvl_d;
      prev_q <= lvl_q;
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && !filt_stb) |=> $stable(lvl_q)); // R9
  AST_FILT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |=> (lvl_q == $past(synced))); // R9
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             uf_q, uf_d;

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    uf_d  = 1'b0;
    if (ld_wr) begin
      rld_d = ld_val;
      if (!run) cnt_d = ld_val;
    end
    if (run && tick) begin
      if (cnt_q == '0) begin
        cnt_d = rld_q;
        uf_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      uf_q  <= uf_d;
    end
  end

  assign count     = cnt_q;
  assign underflow = uf_q;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_wr) |=> $stable(cnt_q)); // R5
  AST_LOAD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wr && !run) |=> (cnt_q == $past(ld_val))); // R2
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
  AST_UF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q |-> (cnt_q == $past(rld_q))); // R6
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sel,
  input  logic [1:0]       ratio_code,
  input  logic             run,
  input  logic             event_mode,
  input  logic             edge_pol,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_wr,
  input  logic             lo_stb,
  input  logic             hi_stb,
  input  logic             hi_on,
  input  logic             filt_stb,
  input  logic             evt_pin,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  logic psc_en, psc_tick, evt_tick, cnt_tick;

  assign psc_en = run & ~event_mode;

  cdt_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .en(psc_en),
    .src_sel(src_sel), .hi_on(hi_on), .lo_stb(lo_stb), .hi_stb(hi_stb),
    .ratio(ratio_code), .tick(psc_tick)
  );

  cdt_evt_filter #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin), .filt_en(filt_en),
    .filt_stb(filt_stb), .pol(edge_pol), .edge_tick(evt_tick)
  );

  assign cnt_tick = event_mode ? evt_tick : psc_tick;

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(cnt_tick),
    .ld_wr(reload_wr), .ld_val(reload_val), .count(count), .underflow(underflow)
  );

  AST_EVT_NO_PSC: assert property (@(posedge clk) disable iff (!rst_n)
    event_mode |-> !psc_tick); // R7
endmodule

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 0, run = 0, event_mode = 0, edge_pol = 0, filt_en = 0;
  logic [1:0] ratio_code = 0;
  logic [W-1:0] reload_val = 0;
  logic reload_wr = 0, lo_stb = 0, hi_stb = 0, hi_on = 0, filt_stb = 0, evt_pin = 0;
  logic [W-1:0] count;
  logic underflow;
  logic fs_on = 0;
  logic [1:0] fsc = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    fsc      <= fsc + 1'b1;
    filt_stb <= fs_on && (fsc == 2'd0);
  end

  cdt_timer #(.CNT_W(W)) u_cdt_timer (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ratio_code(ratio_code),
    .run(run), .event_mode(event_mode), .edge_pol(edge_pol), .filt_en(filt_en),
    .reload_val(reload_val), .reload_wr(reload_wr), .lo_stb(lo_stb),
    .hi_stb(hi_stb), .hi_on(hi_on), .filt_stb(filt_stb), .evt_pin(evt_pin),
    .count(count), .underflow(underflow)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_lo(input int n);
    repeat (n) begin
      @(negedge clk); lo_stb = 1'b1;
      @(negedge clk); lo_stb = 1'b0;
    end
  endtask

  task automatic pulse_hi(input int n);
    repeat (n) begin
      @(negedge clk); hi_stb = 1'b1;
      @(negedge clk); hi_stb = 1'b0;
    end
  endtask

  task automatic load(input int v);
    @(negedge clk); run = 1'b0; reload_val = W'(v); reload_wr = 1'b1;
    @(negedge clk); reload_wr = 1'b0;
  endtask

  task automatic start();
    @(negedge clk); run = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count after reset", count, 0);
    check("R1 underflow after reset", underflow, 0);
  endtask

  task automatic t_load_stopped();
    load(10);
    check("R2 load while stopped", count, 10);
  endtask

  task automatic t_ratios();
    int divs[4] = '{1, 4, 32, 256};
    src_sel = 0;
    for (int c = 0; c < 4; c++) begin
      ratio_code = 2'(c);
      load(5);
      start();
      pulse_lo(divs[c] - 1);
      check($sformatf("R3 code %0d before full period", c), count, 5);
      pulse_lo(1);
      check($sformatf("R3 code %0d after full period", c), count, 4);
      run = 1'b0;
    end
  endtask

  task automatic t_source();
    ratio_code = 0;
    load(20);
    src_sel = 1; hi_on = 0;
    start();
    pulse_hi(3);
    check("R4 fast strobe ignored while off", count, 20);
    pulse_lo(2);
    check("R4 slow strobe ignored when fast selected", count, 20);
    hi_on = 1;
    pulse_hi(1);
    check("R4 fast strobe counted", count, 19);
    src_sel = 0;
    pulse_hi(2);
    check("R4 fast strobe ignored when slow selected", count, 19);
    pulse_lo(1);
    check("R4 slow strobe counted", count, 18);
    run = 0;
  endtask

  task automatic t_hold_restart();
    ratio_code = 2'd1;
    load(9);
    start();
    pulse_lo(2);
    @(negedge clk); run = 0;
    pulse_lo(5);
    check("R5 count held while stopped", count, 9);
    start();
    pulse_lo(2);
    check("R5 prescaler cleared on restart", count, 9);
    pulse_lo(2);
    check("R5 tick after full period from restart", count, 8);
    run = 0;
  endtask

  task automatic t_underflow();
    ratio_code = 0;
    load(2);
    start();
    pulse_lo(1);
    check("R6 decrement", count, 1);
    pulse_lo(1);
    check("R6 reach zero", count, 0);
    check("R6 no underflow at zero", underflow, 0);
    pulse_lo(1);
    check("R6 reload on tick at zero", count, 2);
    check("R6 underflow pulse", underflow, 1);
    @(negedge clk);
    check("R6 underflow lasts one cycle", underflow, 0);
    reload_val = 8'd7; reload_wr = 1;
    @(negedge clk); reload_wr = 0;
    check("R2 write while running leaves count", count, 2);
    pulse_lo(2);
    check("R6 count down to zero", count, 0);
    pulse_lo(1);
    check("R2 new reload value used at wrap", count, 7);
    check("R6 underflow on second wrap", underflow, 1);
    run = 0;
  endtask

  task automatic t_event();
    event_mode = 1; filt_en = 0; edge_pol = 1; ratio_code = 0; src_sel = 0;
    load(5);
    start();
    pulse_lo(3);
    check("R7 source strobes ignored in event mode", count, 5);
    evt_pin = 1; idle(6);
    check("R8 rising edge counted with pol 1", count, 4);
    evt_pin = 0; idle(6);
    check("R8 falling edge ignored with pol 1", count, 4);
    edge_pol = 0;
    evt_pin = 1; idle(6);
    check("R8 rising edge ignored with pol 0", count, 4);
    evt_pin = 0; idle(6);
    check("R8 falling edge counted with pol 0", count, 3);
  endtask

  task automatic t_filter();
    edge_pol = 1; filt_en = 1; fs_on = 1;
    idle(16);
    @(negedge clk); evt_pin = 1;
    idle(2); evt_pin = 0;
    idle(20);
    check("R9 short glitch rejected by filter", count, 3);
    evt_pin = 1; idle(20);
    check("R9 stable level accepted by filter", count, 2);
    evt_pin = 0; idle(20);
    check("R9 falling ignored with pol 1", count, 2);
    filt_en = 0; idle(4);
    @(negedge clk); evt_pin = 1;
    idle(2); evt_pin = 0;
    idle(8);
    check("R9 glitch counted without filter", count, 1);
    run = 0; fs_on = 0; event_mode = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset();
    t_load_stopped();
    t_ratios();
    t_source();
    t_hold_restart();
    t_underflow();
    t_event();
    t_filter();
    idle(2);
    summary();
    $finish;
  end
endmodule